// File: doc/BRIEF.md
# Shared Bus Arbiter for CPU and DMA Requesters

This block decides, cycle by cycle, which of two masters owns a shared memory bus: a processor and a DMA engine. Either side may raise a request in any cycle. The DMA side also presents a two-bit urgency code for the transfer it is running, and that code settles what happens when both sides ask at once (a *contest*).

There are four urgency levels:

| Code | Contest outcome |
|------|-----------------|
| 0 | The CPU is favoured. |
| 1 | Alternation. The DMA may lose a contest, but never twice in a row. |
| 2 | The DMA is favoured. |
| 3 | The DMA is favoured, the strongest level. |

In this two-master arbiter, codes 2 and 3 settle contests the same way.

For code 1, a single *owed* bit remembers that the DMA lost its last alternating contest. The next such contest then goes to the DMA.

The grant logic is a three-state machine whose state is the current owner:

- States:
  - `ST_IDLE`: nobody granted.
  - `ST_CPU`: the CPU holds the grant.
  - `ST_DMA`: the DMA holds the grant.
- Transitions are evaluated on every clock edge from the sampled requests:
  - *to_idle* when there is no request.
  - *to_cpu* when the CPU is the winner.
  - *to_dma* when the DMA is the winner.
  - Any state can reach any state.

The grant outputs are decoded from that state, so each is a register output. A request sampled at a rising edge shows up as the matching grant right after that edge.

Top module: `bus_prio_arb`

## Requirements
- R1: While reset is asserted, and after it is released, both grants are 0 and the owed bit is clear. A code-1 contest right after reset goes to the CPU.
- R2: The grants follow the requests sampled at the previous rising edge and last one cycle per sampled cycle. With no request sampled, both grants are 0 after that edge.
- R3: `cpu_gnt` and `dma_gnt` are never 1 together.
- R4: A request from only one master is granted after that edge, whatever the code.
- R5: In a contest with code 0, the CPU is granted.
- R6: In a contest with code 2, the DMA is granted.
- R7: In a contest with code 3, the DMA is granted.
- R8: In a contest with code 1 and the owed bit clear, the CPU is granted and the owed bit is set. With the owed bit set, the DMA is granted.
- R9: Over the code-1 contests, the DMA never loses two in a row unless the DMA is granted in between. This holds even when cycles with no contest or with other codes lie between those contests.
- R10: Any DMA grant clears the owed bit. This includes an uncontested DMA grant and a contest won at code 2 or 3.
- R11: A code-0 contest leaves the owed bit unchanged. After a lost code-1 contest, a code-0 contest won by the CPU does not stop the DMA from winning the next code-1 contest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU asks for the bus this cycle |
| dma_req | input | 1 | DMA asks for the bus this cycle |
| dma_prio | input | PRIO_W | DMA urgency code (0 low, 1 alternating, 2 high, 3 highest) |
| cpu_gnt | output | 1 | Registered grant to the CPU |
| dma_gnt | output | 1 | Registered grant to the DMA |

## Verification
The bench builds the arbiter with the default code width of two bits, so all four urgency codes can be reached, including the split between codes 2 and 3.

Directed sequences cover these cases:
- reset clearing a pending owed bit;
- a DMA-only grant clearing it;
- code-0 contests inserted between alternating contests;
- back-to-back contests at each code.

A random phase then mixes requests and codes. It checks every cycle against a behavioural model, and it separately counts consecutive code-1 losses for the DMA.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CPU  = 2'd1,
        ST_DMA  = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic to_cpu;
        logic to_dma;
        logic alt_contest;
    } pick_t;

endpackage

// File: rtl/bpa_winner.sv
module bpa_winner
    import bpa_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input  logic              cpu_req,
    input  logic              dma_req,
    input  logic [PRIO_W-1:0] dma_prio,
    input  logic              owed,
    output pick_t             pick
);

    localparam logic [PRIO_W-1:0] LVL_LOW = PRIO_W'(0);
    localparam logic [PRIO_W-1:0] LVL_ALT = PRIO_W'(1);

    logic contest;
    assign contest = cpu_req && dma_req;

    always_comb begin
        pick = '0;
        pick.alt_contest = contest && (dma_prio == LVL_ALT);
        if (contest) begin
            if (dma_prio == LVL_LOW) begin
                pick.to_cpu = 1'b1;
            end else if (dma_prio == LVL_ALT) begin
                pick.to_dma = owed;
                pick.to_cpu = !owed;
            end else begin
                pick.to_dma = 1'b1;
            end
        end else begin
            pick.to_cpu = cpu_req;
            pick.to_dma = dma_req;
        end
    end

endmodule

// File: rtl/bpa_fair.sv
module bpa_fair (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_contest,
    input  logic dma_win,
    output logic owed_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= 1'b0;
        end else if (dma_win) begin
            owed_q <= 1'b0;
        end else if (alt_contest) begin
            owed_q <= 1'b1;
        end
    end

    AST_OWED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dma_win) |-> !owed_q); // R10

endmodule

// File: rtl/bus_prio_arb.sv
module bus_prio_arb
    import bpa_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              dma_req,
    input  logic [PRIO_W-1:0] dma_prio,
    output logic              cpu_gnt,
    output logic              dma_gnt
);

    localparam logic [PRIO_W-1:0] LVL_LOW = PRIO_W'(0);
    localparam logic [PRIO_W-1:0] LVL_ALT = PRIO_W'(1);

    arb_state_t state_q, state_d;
    pick_t      pick;
    logic       owed_q;

    bpa_winner #(.PRIO_W(PRIO_W)) i_winner (
        .cpu_req  (cpu_req),
        .dma_req  (dma_req),
        .dma_prio (dma_prio),
        .owed     (owed_q),
        .pick     (pick)
    );

    bpa_fair i_fair (
        .clk         (clk),
        .rst_n       (rst_n),
        .alt_contest (pick.alt_contest),
        .dma_win     (pick.to_dma),
        .owed_q      (owed_q)
    );

    always_comb begin
        unique case ({pick.to_dma, pick.to_cpu})
            2'b01:   state_d = ST_CPU;
            2'b10:   state_d = ST_DMA;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cpu_gnt = 1'b0;
        dma_gnt = 1'b0;
        unique case (state_q)
            ST_CPU:  cpu_gnt = 1'b1;
            ST_DMA:  dma_gnt = 1'b1;
            default: ;
        endcase
    end

    // checker-only history of code-1 contests, aligned with the grants
    logic alt_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alt_seen_q <= 1'b0;
        else        alt_seen_q <= cpu_req && dma_req && (dma_prio == LVL_ALT);
    end

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && dma_gnt)); // R3
    AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cpu_req && !dma_req) && $past(rst_n)) |-> (!cpu_gnt && !dma_gnt)); // R2
    AST_SOLO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_req != dma_req) && $past(rst_n)) |-> (cpu_gnt == $past(cpu_req) && dma_gnt == $past(dma_req))); // R4
    AST_LOW_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_req && dma_req && dma_prio == LVL_LOW) && $past(rst_n)) |-> cpu_gnt); // R5
    AST_HIGH_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_req && dma_req && dma_prio[PRIO_W-1]) && $past(rst_n)) |-> dma_gnt); // R6
    AST_ALT_NO_DOUBLE_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_seen_q && cpu_gnt) |=> !(alt_seen_q && cpu_gnt)); // R9

endmodule

// File: tb/test_bus_prio_arb.sv
module test_bus_prio_arb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic       dma_req = 1'b0;
    logic [1:0] dma_prio = 2'd0;
    logic       cpu_gnt, dma_gnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural model state
    bit exp_cpu = 0, exp_dma = 0, owed = 0;
    int alt_losses = 0;

    always #2 clk = ~clk;

    bus_prio_arb #(.PRIO_W(2)) i_bus_prio_arb (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
        .dma_prio(dma_prio), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
    );

    task automatic check(string tag, bit ac, bit ad);
        total++;
        if (cpu_gnt !== ac || dma_gnt !== ad) begin
            bad++;
            $display("FAIL %s: cpu_gnt/dma_gnt = %b%b expected %b%b", tag, cpu_gnt, dma_gnt, ac, ad);
        end
    endtask

    // drive at negedge, model at posedge, compare at following negedge
    task automatic step(string tag, bit c, bit d, logic [1:0] p);
        cpu_req = c; dma_req = d; dma_prio = p;
        @(posedge clk);
        exp_cpu = 0; exp_dma = 0;
        if (c && d) begin
            if (p == 0)      exp_cpu = 1;
            else if (p == 1) begin if (owed) exp_dma = 1; else exp_cpu = 1; end
            else             exp_dma = 1;
        end else begin
            exp_cpu = c; exp_dma = d;
        end
        if (c && d && p == 1) begin
            if (exp_cpu) alt_losses++;
            else         alt_losses = 0;
        end
        if (exp_dma) begin owed = 0; alt_losses = 0; end
        else if (c && d && p == 1) owed = 1;
        @(negedge clk);
        check(tag, exp_cpu, exp_dma);
        if (c && d && p == 1) begin
            total++;
            if (alt_losses > 1) begin
                bad++;
                $display("FAIL R9: consecutive code-1 losses = %0d expected <= 1", alt_losses);
            end
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 0, 0);

        step("R2 idle", 0, 0, 2'd3);
        step("R4 cpu solo code3", 1, 0, 2'd3);
        step("R4 dma solo code0", 0, 1, 2'd0);
        step("R2 drop to idle", 0, 0, 2'd0);
        step("R5 contest code0", 1, 1, 2'd0);
        step("R5 back-to-back code0", 1, 1, 2'd0);
        step("R6 contest code2", 1, 1, 2'd2);
        step("R7 contest code3", 1, 1, 2'd3);
        step("R7 back-to-back code3", 1, 1, 2'd3);
        step("R8 alt first to cpu", 1, 1, 2'd1);
        step("R8 alt second to dma", 1, 1, 2'd1);
        step("R8 alt third to cpu", 1, 1, 2'd1);
        step("R11 code0 contest keeps owed", 1, 1, 2'd0);
        step("R2 cpu only gap", 1, 0, 2'd1);
        step("R9 alt after gap to dma", 1, 1, 2'd1);
        step("R8 alt lose again", 1, 1, 2'd1);
        step("R10 dma solo clears owed", 0, 1, 2'd1);
        step("R10 alt after clear to cpu", 1, 1, 2'd1);
        step("R10 code2 win clears owed", 1, 1, 2'd2);
        step("R10 alt after code2 to cpu", 1, 1, 2'd1);

        // reset must clear a pending owed bit
        @(negedge clk);
        rst_n = 1'b0; cpu_req = 0; dma_req = 0;
        owed = 0; alt_losses = 0;
        @(negedge clk);
        check("R1 reset mid-run", 0, 0);
        rst_n = 1'b1;
        step("R1 alt after reset to cpu", 1, 1, 2'd1);
        step("R8 alt after reset to dma", 1, 1, 2'd1);

        for (int i = 0; i < 3000; i++) begin
            bit c, d;
            logic [1:0] p;
            c = 1'($urandom_range(0, 1));
            d = 1'($urandom_range(0, 1));
            p = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) begin c = 1; d = 1; end
            if ($urandom_range(0, 1) == 0) p = 2'd1;
            step("R9 random", c, d, p);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule